// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit operands over many clock cycles and returns a 64-bit product. It owns a single 32-bit adder and one 64-bit working register. The multiplier operand starts in the lower half of that register, and the upper half starts at zero. On every iteration the block looks at the register's least significant bit. If that bit is set, it adds the multiplicand into the upper half. It then shifts the whole register one place to the right. The adder's carry out enters at the top during this shift, so no product bit is lost.

A caller pulses `start` while the block is idle. The caller can then watch `busy` and wait for the one-cycle `done` pulse, which marks a valid `product`. When `signed_sel` is high, the block reads both operands as two's complement values. It multiplies their magnitudes and negates the 64-bit result when the operand signs differ. The block ignores a new `start` for as long as it is busy.

Top module: `seq_mul`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `product` are all zero.
- R2: A `start` pulse sampled on a clock edge while `busy` is low is accepted. The operands and `signed_sel` are captured on that edge, `busy` is high from that edge on, and `done` stays low.
- R3: `done` is high for exactly one cycle, beginning 33 clock edges after the accepting edge. On the edge after that cycle, `busy` and `done` are both low.
- R4: With `signed_sel` low, `product` equals the full 64-bit unsigned product, including the top bit that comes from the adder carry (0xFFFFFFFF × 0xFFFFFFFF = 0xFFFFFFFE00000001).
- R5: Multiplier bits that are zero add nothing, so a zero multiplier gives a zero product, and a single-bit multiplier gives the multiplicand shifted left.
- R6: With `signed_sel` high, `product` is the two's complement 64-bit product. The block forms it from the magnitudes and negates it when exactly one operand is negative (2 × 3 = 6, −6 × 3 = −18, −6 × −5 = 30, and a zero magnitude product stays zero).
- R7: In signed mode, the magnitude of 0x80000000 is the unsigned value 2^31. For example, 0x80000000 × 0x80000000 = 2^62, × 1 = −2^31, and × −1 = +2^31.
- R8: A `start` pulse sampled while `busy` is high has no effect. The running operation keeps its operands and its timing, and no second `done` follows.
- R9: With `signed_sel` low, bit 31 of an operand is a magnitude bit, not a sign (0xFFFFFFFF × 2 = 0x1FFFFFFFE).
- R10: `product` holds its last result after `done`, through idle cycles and through the busy cycles of the next operation, until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication; honoured only while idle |
| mcand_in | input | 32 | Multiplicand operand |
| mplier_in | input | 32 | Multiplier operand |
| signed_sel | input | 1 | 1 = two's complement operands, 0 = unsigned |
| busy | output | 1 | High from the accepting edge through the done cycle |
| done | output | 1 | One-cycle pulse marking a valid product |
| product | output | 64 | 64-bit result, held until the next completion |

## Verification
Assertions check several properties on every cycle. The done pulse lasts one cycle and idle follows it. An accepted start raises busy. The iteration counter steps by one through the run. A load clears the upper accumulator half and places the multiplier magnitude in the lower half. An iteration with a zero test bit only shifts. A nonzero negated result carries a set sign bit.

Only the bench scenarios can show the arithmetic values. These include the carry into bit 63, the most negative operand, and the signed corner cases. Only the bench can show the exact 33-edge latency, that a start arriving mid-run is ignored, and that the result is held across idle and busy periods.

// File: rtl/smul_pkg.sv
package smul_pkg;

    // Default operand width; the product is twice as wide.
    parameter int unsigned MUL_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2,
        ST_DONE = 2'd3
    } smul_state_t;

endpackage

// File: rtl/smul_prep.sv
module smul_prep #(
    parameter int unsigned W = smul_pkg::MUL_W
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         signed_sel,
    output logic [W-1:0] a_mag,
    output logic [W-1:0] b_mag,
    output logic         neg_res
);

    logic a_neg;
    logic b_neg;

    always_comb begin
        a_neg   = signed_sel & a_in[W-1];
        b_neg   = signed_sel & b_in[W-1];
        // Two's complement negation; the most negative value maps to 2^(W-1) unsigned.
        a_mag   = a_neg ? (~a_in + W'(1)) : a_in;
        b_mag   = b_neg ? (~b_in + W'(1)) : b_in;
        neg_res = a_neg ^ b_neg;
    end

endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
#(
    parameter int unsigned W = smul_pkg::MUL_W
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic fix,
    output logic busy,
    output logic done
);

    localparam int unsigned CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    smul_state_t   state_q;
    logic [CW-1:0] iter_q;

    always_comb begin
        load = (state_q == ST_IDLE) && start;
        step = (state_q == ST_RUN);
        fix  = (state_q == ST_FIX);
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        iter_q  <= '0;
                    end
                end
                ST_RUN: begin
                    iter_q <= iter_q + CW'(1);
                    if (iter_q == LAST) begin
                        state_q <= ST_FIX;
                    end
                end
                ST_FIX:  state_q <= ST_DONE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3: done is a single-cycle pulse and the block is idle right after it
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R3: the iteration counter advances by one on each run cycle
    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        (step && iter_q != LAST) |=> (step && iter_q == $past(iter_q) + CW'(1)));

    // R2: an accepted start makes the block busy on the next cycle
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done));

    // R8: a start during the run does not restart the count
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        (start && step && iter_q != LAST) |=> (iter_q != '0));

endmodule

// File: rtl/smul_iter.sv
module smul_iter #(
    parameter int unsigned W = smul_pkg::MUL_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   a_mag,
    input  logic [W-1:0]   b_mag,
    output logic [2*W-1:0] acc
);

    localparam int unsigned PW = 2 * W;

    logic [W-1:0] mcand_q;
    logic [PW-1:0] acc_q;
    logic [W:0]   sum;

    // One W-bit add per iteration; the carry becomes the new top bit.
    always_comb begin
        sum = {1'b0, acc_q[PW-1:W]} + {1'b0, (acc_q[0] ? mcand_q : '0)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            acc_q   <= '0;
        end else if (load) begin
            mcand_q <= a_mag;
            acc_q   <= {{W{1'b0}}, b_mag};
        end else if (step) begin
            acc_q   <= {sum, acc_q[W-1:1]};
        end
    end

    assign acc = acc_q;

    // R4: load clears the upper half and seats the multiplier magnitude below it
    a_r4_load_seat: assert property (@(posedge clk) disable iff (rst)
        load |=> (acc_q[PW-1:W] == '0 && acc_q[W-1:0] == $past(b_mag)));

    // R5: a zero test bit only shifts the register, nothing is added
    a_r5_no_add: assert property (@(posedge clk) disable iff (rst)
        (step && !acc_q[0]) |=> (acc_q == {1'b0, $past(acc_q[PW-1:1])}));

endmodule

// File: rtl/seq_mul.sv
module seq_mul
    import smul_pkg::*;
#(
    parameter int unsigned W = smul_pkg::MUL_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    input  logic           signed_sel,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);

    localparam int unsigned PW = 2 * W;

    logic          load;
    logic          step;
    logic          fix;
    logic [W-1:0]  a_mag;
    logic [W-1:0]  b_mag;
    logic          neg_now;
    logic          neg_q;
    logic [PW-1:0] acc;
    logic [PW-1:0] res_q;

    smul_prep #(.W(W)) u_prep (
        .a_in       (mcand_in),
        .b_in       (mplier_in),
        .signed_sel (signed_sel),
        .a_mag      (a_mag),
        .b_mag      (b_mag),
        .neg_res    (neg_now)
    );

    smul_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .fix   (fix),
        .busy  (busy),
        .done  (done)
    );

    smul_iter #(.W(W)) u_iter (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .step  (step),
        .a_mag (a_mag),
        .b_mag (b_mag),
        .acc   (acc)
    );

    // Sign fix: 64-bit negation of the magnitude product when signs differed.
    always_ff @(posedge clk) begin
        if (rst) begin
            neg_q <= 1'b0;
            res_q <= '0;
        end else begin
            if (load) begin
                neg_q <= neg_now;
            end
            if (fix) begin
                res_q <= neg_q ? (~acc + PW'(1)) : acc;
            end
        end
    end

    assign product = res_q;

    // R6: a negated nonzero result is negative
    a_r6_neg_sign: assert property (@(posedge clk) disable iff (rst)
        (fix && neg_q && acc != '0) |=> product[PW-1]);

    // R10: the result only changes when a completion is being formed
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !fix |=> $stable(product));

endmodule

// File: tb/test_seq_mul.sv
module test_seq_mul;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [W-1:0]  mcand_in;
    logic [W-1:0]  mplier_in;
    logic          signed_sel;
    logic          busy;
    logic          done;
    logic [63:0]   product;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    seq_mul #(.W(W)) i_seq_mul (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mcand_in   (mcand_in),
        .mplier_in  (mplier_in),
        .signed_sel (signed_sel),
        .busy       (busy),
        .done       (done),
        .product    (product)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%016h expected=0x%016h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                            input bit sm);
        longint sa;
        longint sb;
        if (sm) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            return 64'(sa * sb);
        end
        return {32'd0, a} * {32'd0, b};
    endfunction

    // Runs one operation; poke_at > 0 injects a start with other operands mid-run.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit sm,
                          input string req, input int poke_at);
        int cycles;
        logic [63:0] exp;
        exp = ref_mul(a, b, sm);
        @(negedge clk);
        mcand_in = a; mplier_in = b; signed_sel = sm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mcand_in = ~a; mplier_in = b + 32'd7; signed_sel = ~sm;
        check(busy && !done, "R2", {62'd0, busy, done}, 64'd2);
        cycles = 1;
        while (!done && cycles < 200) begin
            if (poke_at > 0 && cycles == poke_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cycles++;
        end
        check(cycles == 34, poke_at > 0 ? "R8" : "R3", 64'(cycles - 1), 64'd33);
        check(product == exp, req, product, exp);
        @(negedge clk);
        check(!busy && !done, "R3", {62'd0, busy, done}, 64'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; mcand_in = '0; mplier_in = '0; signed_sel = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && product == 64'd0, "R1", product, 64'd0);
    endtask

    task automatic t_unsigned();
        run_op(32'd2, 32'd3, 1'b0, "R4", 0);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R4", 0);
        check(product == 64'hFFFF_FFFE_0000_0001, "R4", product, 64'hFFFF_FFFE_0000_0001);
        run_op(32'hFFFF_FFFF, 32'd2, 1'b0, "R9", 0);
        check(product == 64'h1_FFFF_FFFE, "R9", product, 64'h1_FFFF_FFFE);
        run_op(32'h1234_5678, 32'd0, 1'b0, "R5", 0);
        run_op(32'hDEAD_BEEF, 32'h0001_0000, 1'b0, "R5", 0);
    endtask

    task automatic t_signed();
        run_op(32'd2, 32'd3, 1'b1, "R6", 0);
        run_op(-32'sd6, 32'd3, 1'b1, "R6", 0);
        check(product == 64'hFFFF_FFFF_FFFF_FFEE, "R6", product, 64'hFFFF_FFFF_FFFF_FFEE);
        run_op(-32'sd6, -32'sd5, 1'b1, "R6", 0);
        check(product == 64'd30, "R6", product, 64'd30);
        run_op(32'd0, -32'sd5, 1'b1, "R6", 0);
        run_op(32'd7, -32'sd1, 1'b1, "R6", 0);
    endtask

    task automatic t_min_neg();
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, "R7", 0);
        check(product == 64'h4000_0000_0000_0000, "R7", product, 64'h4000_0000_0000_0000);
        run_op(32'h8000_0000, 32'd1, 1'b1, "R7", 0);
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R7", 0);
        check(product == 64'h0000_0000_8000_0000, "R7", product, 64'h8000_0000);
    endtask

    task automatic t_busy_start();
        bit extra;
        run_op(32'd1000, 32'd77, 1'b0, "R8", 10);
        extra = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (done || busy) extra = 1'b1;
        end
        check(!extra, "R8", {63'd0, extra}, 64'd0);
    endtask

    task automatic t_hold();
        logic [63:0] old;
        run_op(32'd123, 32'd456, 1'b0, "R10", 0);
        old = product;
        repeat (5) @(negedge clk);
        check(product == old, "R10", product, old);
        mcand_in = 32'd9; mplier_in = 32'd9; signed_sel = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (15) @(negedge clk);
        check(busy && product == old, "R10", product, old);
        repeat (30) @(negedge clk);
        check(product == 64'd81, "R10", product, 64'd81);
    endtask

    initial begin
        t_reset();
        t_unsigned();
        t_signed();
        t_min_neg();
        t_busy_start();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule